// File: doc/BRIEF.md
# Port pin chip-select decoder

This block controls a single general-purpose port pin. In its plain mode the pin carries the value of an output latch that software writes. In its three decode modes the pin becomes a chip-select strobe. The strobe is produced by comparing the external bus address with a programmed 16-bit match address and then qualifying the result with the read strobe, the write strobe, or either strobe. A length code tells the comparator how many low address bits to ignore, so one strobe can cover an aligned window of 1, 2, 4 or 8 addresses. An inversion bit sets the active level of the strobe.

Software programs the block through a small byte-wide write port. Select code 0 holds the low match byte, code 1 the high match byte, code 2 the control byte, and code 3 the output latch. The control byte packs the function in bits [1:0], the length code in bits [3:2] and the inversion bit in bit [4]. The pad level arriving back from the pin is passed straight onto the internal read path.

Top module: `pin_cs_decoder`

## Requirements
- R1: While `rst` is high the function becomes 00 (data I/O), inversion becomes off, the output latch becomes 1 and both match bytes become 0. `pin_out` is therefore 1 after reset.
- R2: On a rising clock edge with `cfg_we` high, select 0 loads the low match byte and select 1 loads the high match byte from `cfg_wdata`. When `cfg_we` is low, no register changes.
- R3: Length code 00 compares all 16 address bits. A difference in any bit, including bit 0 or a bit of the high byte, means no match.
- R4: Length codes 01, 10 and 11 leave the lowest 1, 2 and 3 address bits out of the comparison. All higher bits must still be equal.
- R5: Function 00 drives `pin_out` from bit 0 of the output latch (select 3). Address, strobes and the inversion bit have no effect in this mode.
- R6: Function 01 makes the select active only while the address matches and `rd_strobe` is high.
- R7: Function 10 makes the select active only while the address matches and `wr_strobe` is high.
- R8: Function 11 makes the select active while the address matches and at least one strobe is high.
- R9: In functions 01 to 11, `pin_out` equals the select when inversion is 0. When inversion is 1, `pin_out` is the complement of the select, so it rests at 1 and goes to 0 while selected.
- R10: `pin_rd` always equals `pin_in` in the same cycle.
- R11: The path from address and strobes to `pin_out` is combinational. A configuration write changes `pin_out` only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 match low, 1 match high, 2 control, 3 latch |
| cfg_wdata | input | 8 | Configuration write data |
| bus_addr | input | 16 | External bus address |
| rd_strobe | input | 1 | Bus read strobe, active high |
| wr_strobe | input | 1 | Bus write strobe, active high |
| pin_in | input | 1 | Level sensed at the pad |
| pin_out | output | 1 | Level driven to the pad |
| pin_rd | output | 1 | Pad level returned to the internal data bus |

## Verification
A wrong match byte or a wrong length code shows up only as a missing or extra strobe, and only for addresses close to the programmed window. For that reason the vectors test addresses that differ in exactly one bit at each length boundary, and one address that differs only in the high byte. A function or inversion bit left stale would change `pin_out` at once for a fixed address and strobe pattern, so each vector is checked in the same cycle its inputs are applied. Configuration errors are checked one clock after the write, and before that edge the bench confirms that the pin has not yet changed.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PCS_ADDR_W = 16;
    localparam int PCS_DATA_W = 8;
    localparam int PCS_LEN_W  = 2;

    typedef enum logic [1:0] {
        FN_IO  = 2'b00,
        FN_RD  = 2'b01,
        FN_WR  = 2'b10,
        FN_ANY = 2'b11
    } pin_fn_e;

    typedef enum logic [1:0] {
        SEL_MLO   = 2'd0,
        SEL_MHI   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_LATCH = 2'd3
    } cfg_sel_e;

    // control byte bits [4:0]: inv, len[1:0], fn[1:0]
    typedef struct packed {
        logic                 inv;
        logic [PCS_LEN_W-1:0] len;
        pin_fn_e              fn;
    } pin_ctrl_t;

    localparam int CTRL_W = $bits(pin_ctrl_t);

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    function automatic logic strobe_qualify(pin_fn_e fn, strobe_t s);
        case (fn)
            FN_RD:   return s.rd;
            FN_WR:   return s.wr;
            FN_ANY:  return s.rd | s.wr;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
    import pcs_pkg::*;
#(
    parameter int ADDR_W = PCS_ADDR_W,
    parameter int DATA_W = PCS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] match_addr,
    output pin_ctrl_t         ctrl,
    output logic              latch
);
    localparam int NBYTES = ADDR_W / DATA_W;

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    match_addr[b*DATA_W +: DATA_W] <= '0;
                end else if (we && sel == 2'(b)) begin
                    match_addr[b*DATA_W +: DATA_W] <= wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '{inv: 1'b0, len: '0, fn: FN_IO};
            latch <= 1'b1;
        end else if (we) begin
            if (sel == SEL_CTRL)  ctrl  <= pin_ctrl_t'(wdata[CTRL_W-1:0]);
            if (sel == SEL_LATCH) latch <= wdata[0];
        end
    end
endmodule

// File: rtl/pcs_addr_cmp.sv
module pcs_addr_cmp
    import pcs_pkg::*;
#(
    parameter int ADDR_W = PCS_ADDR_W,
    parameter int LEN_W  = PCS_LEN_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [LEN_W-1:0]  len,
    output logic              hit
);
    localparam int MAX_SKIP = (1 << LEN_W) - 1;

    logic [ADDR_W-1:0] care;

    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_care
            if (i < MAX_SKIP) begin : g_low
                assign care[i] = (int'(len) <= i);
            end else begin : g_high
                assign care[i] = 1'b1;
            end
        end
    endgenerate

    assign hit = ((addr ^ match_addr) & care) == '0;
endmodule

// File: rtl/pcs_out_mux.sv
module pcs_out_mux
    import pcs_pkg::*;
(
    input  pin_ctrl_t ctrl,
    input  logic      latch,
    input  logic      hit,
    input  strobe_t   strobes,
    output logic      pin_out
);
    logic sel_active;

    always_comb begin
        sel_active = hit & strobe_qualify(ctrl.fn, strobes);
        case (ctrl.fn)
            FN_IO:   pin_out = latch;
            default: pin_out = sel_active ^ ctrl.inv;
        endcase
    end
endmodule

// File: rtl/pin_cs_decoder.sv
module pin_cs_decoder
    import pcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic [15:0] bus_addr,
    input  logic        rd_strobe,
    input  logic        wr_strobe,
    input  logic        pin_in,
    output logic        pin_out,
    output logic        pin_rd
);
    logic [PCS_ADDR_W-1:0] match_addr;
    pin_ctrl_t             ctrl;
    logic                  port_latch;
    logic                  addr_hit;
    strobe_t               strobes;

    assign strobes = '{rd: rd_strobe, wr: wr_strobe};

    pcs_cfg_regs #(.ADDR_W(PCS_ADDR_W), .DATA_W(PCS_DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .match_addr (match_addr),
        .ctrl       (ctrl),
        .latch      (port_latch)
    );

    pcs_addr_cmp #(.ADDR_W(PCS_ADDR_W), .LEN_W(PCS_LEN_W)) u_cmp (
        .addr       (bus_addr),
        .match_addr (match_addr),
        .len        (ctrl.len),
        .hit        (addr_hit)
    );

    pcs_out_mux u_mux (
        .ctrl    (ctrl),
        .latch   (port_latch),
        .hit     (addr_hit),
        .strobes (strobes),
        .pin_out (pin_out)
    );

    assign pin_rd = pin_in;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
    import pcs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [1:0]  cfg_sel,
    input logic [7:0]  cfg_wdata,
    input logic        rd_strobe,
    input logic        wr_strobe,
    input logic        pin_in,
    input logic        pin_out,
    input logic        pin_rd,
    input logic [15:0] match_addr,
    input pin_ctrl_t   ctrl,
    input logic        latch,
    input logic        addr_hit
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl.fn == FN_IO && !ctrl.inv && latch && match_addr == '0));

    p_no_write_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(match_addr) && $stable(ctrl) && $stable(latch)));

    p_ctrl_load_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_CTRL) |=> (ctrl == pin_ctrl_t'($past(cfg_wdata[CTRL_W-1:0]))));

    p_data_mode_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.fn == FN_IO) |-> (pin_out == latch));

    p_miss_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.fn != FN_IO && !addr_hit) |-> (pin_out == ctrl.inv));

    p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.fn != FN_IO && !rd_strobe && !wr_strobe) |-> (pin_out == ctrl.inv));

    p_readback_r10: assert property (@(posedge clk) disable iff (rst)
        pin_rd == pin_in);
endmodule

bind pin_cs_decoder pcs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_rd     (pin_rd),
    .match_addr (match_addr),
    .ctrl       (ctrl),
    .latch      (port_latch),
    .addr_hit   (addr_hit)
);

// File: tb/pin_cs_decoder_test.sv
module pin_cs_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] bus_addr = '0;
    logic        rd_strobe = 1'b0;
    logic        wr_strobe = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_cs_decoder uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .pin_in(pin_in), .pin_out(pin_out), .pin_rd(pin_rd)
    );

    // {ctrl, addr, rd, wr, expected pin_out, requirement}; match address 3A58
    localparam int NV = 19;
    localparam logic [30:0] VEC [NV] = '{
        {8'h01, 16'h3A58, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 read hit
        {8'h01, 16'h3A58, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 write ignored
        {8'h01, 16'h3A59, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 bit0 differs
        {8'h05, 16'h3A59, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 len1 skips bit0
        {8'h05, 16'h3A5B, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 len1 bit1 differs
        {8'h09, 16'h3A5B, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 len2
        {8'h09, 16'h3A5F, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 len2 bit2 differs
        {8'h0D, 16'h3A5F, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 len3
        {8'h0D, 16'h3A50, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 len3 bit3 differs
        {8'h02, 16'h3A58, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 write hit
        {8'h02, 16'h3A58, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 read ignored
        {8'h03, 16'h3A58, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 read
        {8'h03, 16'h3A58, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 write
        {8'h03, 16'h3A58, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 no strobe
        {8'h13, 16'h3A58, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 inverted active
        {8'h13, 16'h3A58, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 inverted idle
        {8'h00, 16'h3A58, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 data mode
        {8'h11, 16'h3A59, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 inverted miss
        {8'h03, 16'hBA58, 1'b0, 1'b1, 1'b0, 4'd3}   // R3 high byte differs
    };

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(pin_out, 1'b1, "R1 reset pin level");
        check(pin_rd, 1'b0, "R10 readback low");
        pin_in = 1'b1; #1;
        check(pin_rd, 1'b1, "R10 readback high");

        wr_cfg(2'd0, 8'h58);  // R2 low byte
        wr_cfg(2'd1, 8'h3A);  // R2 high byte

        for (int i = 0; i < NV; i++) begin
            wr_cfg(2'd2, VEC[i][30:23]);
            bus_addr  = VEC[i][22:7];
            rd_strobe = VEC[i][6];
            wr_strobe = VEC[i][5];
            #1;
            check(pin_out, VEC[i][4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
        end

        // R2: write with cfg_we low must not alter the match address
        wr_cfg(2'd2, 8'h01);
        bus_addr = 16'h3A58; rd_strobe = 1'b1; wr_strobe = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'h00;
        @(negedge clk); @(negedge clk);
        #1;
        check(pin_out, 1'b1, "R2 ignored write keeps match");

        // R11: latch 0 first (select still active), then switch to data mode
        wr_cfg(2'd3, 8'h00);
        #1;
        check(pin_out, 1'b1, "R11 latch write no effect in select mode");
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h00;
        #1;
        check(pin_out, 1'b1, "R11 before capture edge");
        @(posedge clk); #1;
        cfg_we = 1'b0;
        check(pin_out, 1'b0, "R11 after capture edge");

        // R5: data mode ignores address, strobes and inversion
        @(negedge clk);
        bus_addr = 16'h0000; rd_strobe = 1'b0; wr_strobe = 1'b1; #1;
        check(pin_out, 1'b0, "R5 strobes ignored");
        wr_cfg(2'd2, 8'h10);
        #1;
        check(pin_out, 1'b0, "R5 inversion ignored");

        // R1: reset mid-run restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check(pin_out, 1'b1, "R1 reset restores latch");
        wr_cfg(2'd2, 8'h03);
        bus_addr = 16'h0000; wr_strobe = 1'b1; #1;
        check(pin_out, 1'b1, "R1 match cleared to zero");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule